// File: doc/BRIEF.md
# Up/Down Step Potentiometer Sequencer

This block is the host-side driver for a digitally trimmed potentiometer that has a three-line serial control: an active-low select, an active-low step strobe and a direction level. It accepts one command at a time over a valid/ready handshake. A command holds a step count, a direction and a commit flag. The block turns that command into a correctly timed waveform on the three pins. It selects the device and presents the direction with the required setup. It then pulses the step strobe the requested number of times and releases the select.

The level of the step strobe at the moment the select is released tells the device whether to write its wiper position to non-volatile storage. A high strobe at release commits the position. A low strobe at release leaves the stored value unchanged. After a commit, the device needs a long quiet interval, so the block holds the select high and stays busy for a configurable hold-off before it accepts further work.

Every minimum pin timing is a parameter counted in clock cycles. The block also keeps a saturating estimate of the wiper position. Software can preset this estimate through a load input.

Top module: `updn_pot_master`

## Requirements
- R1: After reset, and whenever the block is idle, `pot_sel_n` and `pot_step_n` are both 1, `busy` is 0, `cmd_ready` is 1, and `pos_est` equals `RST_POS` after reset.
- R2: A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both 1. A command that drives the pins raises `busy` and drops `cmd_ready` from the next cycle until its completion. `done` is a single-cycle pulse, asserted while `busy` is 0.
- R3: A command with step count N produces exactly N falling edges on `pot_step_n`, all while `pot_sel_n` is 0. At each falling edge, `pos_est` moves by one, upward when `cmd_up` is 1 and downward otherwise, and it saturates at 0 and `POS_MAX`.
- R4: The first falling edge of `pot_step_n` comes at least `T_CS_SETUP` cycles after `pot_sel_n` falls. `pot_dir` is stable for at least `T_DIR_SETUP` cycles before every falling edge. `pot_dir` changes only while `pot_step_n` is 1 and has been 1 for at least `T_DIR_HOLD` cycles.
- R5: While the device is selected, every low phase of `pot_step_n` lasts at least `T_INC_LO` cycles and every high phase between two falls lasts at least `T_INC_HI` cycles. Consecutive falls are at least `T_CYC_MIN` cycles apart.
- R6: With `cmd_store` = 1, `pot_sel_n` rises while `pot_step_n` is 1, at least `T_TAIL` cycles after the last edge of `pot_step_n` (or after the select fell, when there is none). `pot_sel_n` then stays 1 for at least `T_STORE` cycles, and `cmd_ready` stays 0 through that hold-off.
- R7: With `cmd_store` = 0 and N ≥ 1, the last step pulse is left low. `pot_sel_n` rises while `pot_step_n` is 0, at least `T_TAIL` cycles after that last fall, and `pot_step_n` stays 0 for at least `T_DESEL` cycles after the release.
- R8: A command with N = 0 and `cmd_store` = 0 leaves all three pins untouched and pulses `done` in the cycle after acceptance.
- R9: A command with N = 0 and `cmd_store` = 1 selects the device, makes no step edge, and performs a commit release followed by the hold-off.
- R10: `load_en` = 1 sets `pos_est` at the next clock edge to `load_pos`, clamped to `POS_MAX`. A load takes priority over a step that falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_steps | input | STEP_W | Number of step pulses |
| cmd_up | input | 1 | 1 moves the wiper up, 0 moves it down |
| cmd_store | input | 1 | 1 commits the position at release |
| load_en | input | 1 | Preset the position estimate |
| load_pos | input | POS_W | Value for the preset |
| pot_sel_n | output | 1 | Active-low device select |
| pot_step_n | output | 1 | Active-low step strobe; a falling edge makes one step |
| pot_dir | output | 1 | Direction level, 1 = up |
| busy | output | 1 | A command is on the pins or in hold-off |
| done | output | 1 | One-cycle completion pulse |
| pos_est | output | POS_W | Saturating wiper position estimate |

## Verification
The bench builds the block with short timings: a 3-cycle setup, a 3-cycle low phase, a 2-cycle high phase with a 7-cycle fall-to-fall minimum, a 4-cycle tail, a 2-cycle deselect and direction hold, and a 40-cycle commit hold-off. With these values, the stretched final low phase, the high phase lengthened by the cycle minimum, and a 127-step run into the top clamp all fit in a short run. The hold-off stays long enough to see `cmd_ready` held low through it. A pin monitor in the bench measures every phase against these minimums, independently of the design. A command held back-to-back behind a commit checks the hold-off gap.

// File: rtl/updn_pot_pkg.sv
package updn_pot_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE,   // pins parked high, waiting for a command
        ST_SETUP,  // selected, direction settling before first fall
        ST_LOW,    // strobe low phase of a pulse
        ST_HIGH,   // strobe high phase between pulses
        ST_TAIL,   // quiet interval before release
        ST_DESEL,  // released without commit, strobe still low
        ST_RELAX,  // strobe back high before direction may move
        ST_HOLD    // commit hold-off, select kept high
    } pot_state_e;

    // Per-command mode latched at acceptance
    typedef struct packed {
        logic up;
        logic commit;
    } pot_mode_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Length of the high phase: honour both the high minimum and the cycle minimum
    function automatic int unsigned high_len(input int unsigned t_hi,
                                             input int unsigned t_lo,
                                             input int unsigned t_cyc);
        int unsigned rest;
        rest = (t_cyc > t_lo) ? (t_cyc - t_lo) : 1;
        return umax(t_hi, rest);
    endfunction
endpackage

// File: rtl/updn_pot_timer.sv
module updn_pot_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/updn_pot_posest.sv
module updn_pot_posest #(
    parameter int unsigned POS_W   = 7,
    parameter int unsigned POS_MAX = 99,
    parameter int unsigned RST_POS = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [POS_W-1:0] load_val,
    input  logic             step_fire,
    input  logic             step_up,
    output logic [POS_W-1:0] pos
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [POS_W-1:0] TOP = POS_W'(POS_MAX);
    localparam logic [POS_W-1:0] INI = POS_W'(RST_POS);

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= INI;
        end else if (load_en) begin
            pos_q <= (load_val > TOP) ? TOP : load_val;
        end else if (step_fire) begin
            if (step_up) begin
                pos_q <= (pos_q >= TOP) ? TOP : pos_q + 1'b1;
            end else begin
                pos_q <= (pos_q == '0) ? '0 : pos_q - 1'b1;
            end
        end
    end

    assign pos = pos_q;
endmodule

// File: rtl/updn_pot_seq.sv
module updn_pot_seq
    import updn_pot_pkg::*;
#(
    parameter int unsigned STEP_W      = 7,
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SETUP_CYC   = 1,
    parameter int unsigned LO_CYC      = 1,
    parameter int unsigned HI_CYC      = 1,
    parameter int unsigned LAST_LO_CYC = 1,
    parameter int unsigned TAIL_CYC    = 1,
    parameter int unsigned DESEL_CYC   = 1,
    parameter int unsigned RELAX_CYC   = 1,
    parameter int unsigned STORE_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [STEP_W-1:0] cmd_steps,
    input  logic              cmd_up,
    input  logic              cmd_store,
    output logic              cmd_ready,
    output logic              busy,
    output logic              done,
    output logic              sel_n,
    output logic              step_n,
    output logic              dir,
    output logic              step_fire,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    input  logic              tmr_zero
);
    timeunit 1ns;
    timeprecision 1ps;

    pot_state_e        st_q, st_d;
    pot_mode_t         mode_q, mode_d;
    logic [STEP_W-1:0] rem_q, rem_d;
    logic              sel_q, sel_d;
    logic              stp_q, stp_d;
    logic              dir_q, dir_d;
    logic              done_q, done_d;
    logic              last_fall;

    // The pulse about to fall is the final one of an uncommitted update
    assign last_fall = (rem_q == STEP_W'(1)) && !mode_q.commit;

    always_comb begin
        st_d      = st_q;
        mode_d    = mode_q;
        rem_d     = rem_q;
        sel_d     = sel_q;
        stp_d     = stp_q;
        dir_d     = dir_q;
        done_d    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        step_fire = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    mode_d.up     = cmd_up;
                    mode_d.commit = cmd_store;
                    rem_d         = cmd_steps;
                    if (cmd_steps == '0 && !cmd_store) begin
                        done_d = 1'b1;
                    end else begin
                        sel_d    = 1'b0;
                        dir_d    = cmd_up;
                        st_d     = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(SETUP_CYC - 1);
                    end
                end
            end
            ST_SETUP, ST_HIGH: begin
                if (tmr_zero) begin
                    if (rem_q == '0) begin
                        st_d     = ST_TAIL;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(TAIL_CYC - 1);
                    end else begin
                        stp_d     = 1'b0;
                        step_fire = 1'b1;
                        rem_d     = rem_q - 1'b1;
                        tmr_load  = 1'b1;
                        if (last_fall) begin
                            st_d    = ST_TAIL;
                            tmr_val = CNT_W'(LAST_LO_CYC - 1);
                        end else begin
                            st_d    = ST_LOW;
                            tmr_val = CNT_W'(LO_CYC - 1);
                        end
                    end
                end
            end
            ST_LOW: begin
                if (tmr_zero) begin
                    stp_d    = 1'b1;
                    tmr_load = 1'b1;
                    if (rem_q == '0) begin
                        st_d    = ST_TAIL;
                        tmr_val = CNT_W'(TAIL_CYC - 1);
                    end else begin
                        st_d    = ST_HIGH;
                        tmr_val = CNT_W'(HI_CYC - 1);
                    end
                end
            end
            ST_TAIL: begin
                if (tmr_zero) begin
                    sel_d    = 1'b1;
                    tmr_load = 1'b1;
                    if (mode_q.commit) begin
                        st_d    = ST_HOLD;
                        tmr_val = CNT_W'(STORE_CYC - 1);
                    end else begin
                        st_d    = ST_DESEL;
                        tmr_val = CNT_W'(DESEL_CYC - 1);
                    end
                end
            end
            ST_DESEL: begin
                if (tmr_zero) begin
                    stp_d    = 1'b1;
                    st_d     = ST_RELAX;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RELAX_CYC - 1);
                end
            end
            ST_RELAX, ST_HOLD: begin
                if (tmr_zero) begin
                    st_d   = ST_IDLE;
                    done_d = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mode_q <= '0;
            rem_q  <= '0;
            sel_q  <= 1'b1;
            stp_q  <= 1'b1;
            dir_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            mode_q <= mode_d;
            rem_q  <= rem_d;
            sel_q  <= sel_d;
            stp_q  <= stp_d;
            dir_q  <= dir_d;
            done_q <= done_d;
        end
    end

    assign cmd_ready = (st_q == ST_IDLE);
    assign busy      = (st_q != ST_IDLE);
    assign done      = done_q;
    assign sel_n     = sel_q;
    assign step_n    = stp_q;
    assign dir       = dir_q;
endmodule

// File: rtl/updn_pot_master.sv
module updn_pot_master
    import updn_pot_pkg::*;
#(
    parameter int unsigned STEP_W      = 7,
    parameter int unsigned POS_W       = 7,
    parameter int unsigned POS_MAX     = 99,
    parameter int unsigned RST_POS     = 0,
    parameter int unsigned T_CS_SETUP  = 5,
    parameter int unsigned T_DIR_SETUP = 100,
    parameter int unsigned T_INC_LO    = 96,
    parameter int unsigned T_INC_HI    = 96,
    parameter int unsigned T_CYC_MIN   = 200,
    parameter int unsigned T_DIR_HOLD  = 10,
    parameter int unsigned T_TAIL      = 100,
    parameter int unsigned T_DESEL     = 10,
    parameter int unsigned T_STORE     = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [STEP_W-1:0] cmd_steps,
    input  logic              cmd_up,
    input  logic              cmd_store,
    input  logic              load_en,
    input  logic [POS_W-1:0]  load_pos,
    output logic              pot_sel_n,
    output logic              pot_step_n,
    output logic              pot_dir,
    output logic              busy,
    output logic              done,
    output logic [POS_W-1:0]  pos_est
);
    timeunit 1ns;
    timeprecision 1ps;

    // Phase lengths in cycles, each at least one
    localparam int unsigned SETUP_CYC   = umax(1, umax(T_CS_SETUP, T_DIR_SETUP));
    localparam int unsigned LO_CYC      = umax(1, T_INC_LO);
    localparam int unsigned HI_CYC      = umax(1, high_len(T_INC_HI, T_INC_LO, T_CYC_MIN));
    localparam int unsigned LAST_LO_CYC = umax(LO_CYC, T_TAIL);
    localparam int unsigned TAIL_CYC    = umax(1, T_TAIL);
    localparam int unsigned DESEL_CYC   = umax(1, T_DESEL);
    localparam int unsigned RELAX_CYC   = umax(1, T_DIR_HOLD);
    localparam int unsigned STORE_CYC   = umax(1, T_STORE);
    localparam int unsigned LONGEST     = umax(umax(umax(SETUP_CYC, HI_CYC), umax(LAST_LO_CYC, TAIL_CYC)),
                                               umax(umax(DESEL_CYC, RELAX_CYC), STORE_CYC));
    localparam int unsigned CNT_W       = $clog2(LONGEST + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             step_fire;

    updn_pot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    updn_pot_seq #(
        .STEP_W      (STEP_W),
        .CNT_W       (CNT_W),
        .SETUP_CYC   (SETUP_CYC),
        .LO_CYC      (LO_CYC),
        .HI_CYC      (HI_CYC),
        .LAST_LO_CYC (LAST_LO_CYC),
        .TAIL_CYC    (TAIL_CYC),
        .DESEL_CYC   (DESEL_CYC),
        .RELAX_CYC   (RELAX_CYC),
        .STORE_CYC   (STORE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_steps (cmd_steps),
        .cmd_up    (cmd_up),
        .cmd_store (cmd_store),
        .cmd_ready (cmd_ready),
        .busy      (busy),
        .done      (done),
        .sel_n     (pot_sel_n),
        .step_n    (pot_step_n),
        .dir       (pot_dir),
        .step_fire (step_fire),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .tmr_zero  (tmr_zero)
    );

    updn_pot_posest #(
        .POS_W   (POS_W),
        .POS_MAX (POS_MAX),
        .RST_POS (RST_POS)
    ) u_pos (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .load_val  (load_pos),
        .step_fire (step_fire),
        .step_up   (pot_dir),
        .pos       (pos_est)
    );
endmodule

// File: rtl/updn_pot_chk.sv
module updn_pot_chk #(
    parameter int unsigned POS_W      = 7,
    parameter int unsigned POS_MAX    = 99,
    parameter int unsigned T_INC_LO   = 1,
    parameter int unsigned T_DIR_HOLD = 1,
    parameter int unsigned T_DESEL    = 1,
    parameter int unsigned T_STORE    = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_ready,
    input logic             load_en,
    input logic [POS_W-1:0] load_pos,
    input logic             pot_sel_n,
    input logic             pot_step_n,
    input logic             pot_dir,
    input logic             busy,
    input logic             done,
    input logic [POS_W-1:0] pos_est
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [31:0] lo_run, hi_run, selhi_run;
    logic        sel_prev, committed;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_run    <= '0;
            hi_run    <= '1;
            selhi_run <= '1;
            sel_prev  <= 1'b1;
            committed <= 1'b0;
        end else begin
            lo_run    <= pot_step_n ? '0 : ((lo_run == '1) ? lo_run : lo_run + 1);
            hi_run    <= !pot_step_n ? '0 : ((hi_run == '1) ? hi_run : hi_run + 1);
            selhi_run <= !pot_sel_n ? '0 : ((selhi_run == '1) ? selhi_run : selhi_run + 1);
            sel_prev  <= pot_sel_n;
            if (pot_sel_n && !sel_prev) committed <= pot_step_n;
        end
    end

    a_r1_idle_pins: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pot_sel_n && pot_step_n));

    a_r2_ready_low_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cmd_ready);

    a_r2_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r3_fall_selected: assert property (@(posedge clk) disable iff (rst)
        $fell(pot_step_n) |-> !pot_sel_n);

    a_r3_range: assert property (@(posedge clk) disable iff (rst)
        pos_est <= POS_W'(POS_MAX));

    a_r4_dir_moves_high: assert property (@(posedge clk) disable iff (rst)
        !$stable(pot_dir) |-> (pot_step_n && hi_run >= T_DIR_HOLD));

    a_r5_low_width: assert property (@(posedge clk) disable iff (rst)
        $rose(pot_step_n) |-> (lo_run >= T_INC_LO));

    a_r6_holdoff: assert property (@(posedge clk) disable iff (rst)
        ($fell(pot_sel_n) && committed) |-> (selhi_run >= T_STORE));

    a_r7_desel_low: assert property (@(posedge clk) disable iff (rst)
        ($rose(pot_step_n) && pot_sel_n) |-> (selhi_run >= T_DESEL));

    a_r10_load: assert property (@(posedge clk) disable iff (rst)
        (load_en && load_pos <= POS_W'(POS_MAX)) |=> (pos_est == $past(load_pos)));

    a_r10_clamp: assert property (@(posedge clk) disable iff (rst)
        (load_en && load_pos > POS_W'(POS_MAX)) |=> (pos_est == POS_W'(POS_MAX)));
endmodule

bind updn_pot_master updn_pot_chk #(
    .POS_W      (POS_W),
    .POS_MAX    (POS_MAX),
    .T_INC_LO   (T_INC_LO),
    .T_DIR_HOLD (T_DIR_HOLD),
    .T_DESEL    (T_DESEL),
    .T_STORE    (T_STORE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_ready  (cmd_ready),
    .load_en    (load_en),
    .load_pos   (load_pos),
    .pot_sel_n  (pot_sel_n),
    .pot_step_n (pot_step_n),
    .pot_dir    (pot_dir),
    .busy       (busy),
    .done       (done),
    .pos_est    (pos_est)
);

// File: tb/tb_updn_pot_master.sv
module tb_updn_pot_master;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned STEP_W      = 7;
    localparam int unsigned POS_W       = 7;
    localparam int unsigned POS_MAX     = 99;
    localparam int unsigned T_CS_SETUP  = 2;
    localparam int unsigned T_DIR_SETUP = 3;
    localparam int unsigned T_INC_LO    = 3;
    localparam int unsigned T_INC_HI    = 2;
    localparam int unsigned T_CYC_MIN   = 7;
    localparam int unsigned T_DIR_HOLD  = 2;
    localparam int unsigned T_TAIL      = 4;
    localparam int unsigned T_DESEL     = 2;
    localparam int unsigned T_STORE     = 40;

    // rel: 0 released with strobe low, 1 released with strobe high, 2 never selected
    typedef struct packed {
        logic [6:0] pre;
        logic [6:0] n;
        logic       up;
        logic       st;
        logic [6:0] exp;
        logic [1:0] rel;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{7'd10,  7'd5,   1'b1, 1'b0, 7'd15, 2'd0},
        '{7'd50,  7'd3,   1'b0, 1'b1, 7'd47, 2'd1},
        '{7'd97,  7'd6,   1'b1, 1'b0, 7'd99, 2'd0},
        '{7'd2,   7'd5,   1'b0, 1'b1, 7'd0,  2'd1},
        '{7'd40,  7'd0,   1'b1, 1'b1, 7'd40, 2'd1},
        '{7'd33,  7'd0,   1'b0, 1'b0, 7'd33, 2'd2},
        '{7'd0,   7'd127, 1'b1, 1'b0, 7'd99, 2'd0},
        '{7'd99,  7'd1,   1'b0, 1'b0, 7'd98, 2'd0},
        '{7'd120, 7'd0,   1'b1, 1'b0, 7'd99, 2'd2}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [STEP_W-1:0] cmd_steps = '0;
    logic              cmd_up = 1'b0;
    logic              cmd_store = 1'b0;
    logic              load_en = 1'b0;
    logic [POS_W-1:0]  load_pos = '0;
    logic              pot_sel_n, pot_step_n, pot_dir, busy, done;
    logic [POS_W-1:0]  pos_est;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    updn_pot_master #(
        .STEP_W(STEP_W), .POS_W(POS_W), .POS_MAX(POS_MAX), .RST_POS(0),
        .T_CS_SETUP(T_CS_SETUP), .T_DIR_SETUP(T_DIR_SETUP), .T_INC_LO(T_INC_LO),
        .T_INC_HI(T_INC_HI), .T_CYC_MIN(T_CYC_MIN), .T_DIR_HOLD(T_DIR_HOLD),
        .T_TAIL(T_TAIL), .T_DESEL(T_DESEL), .T_STORE(T_STORE)
    ) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_steps(cmd_steps), .cmd_up(cmd_up), .cmd_store(cmd_store),
        .load_en(load_en), .load_pos(load_pos), .pot_sel_n(pot_sel_n),
        .pot_step_n(pot_step_n), .pot_dir(pot_dir), .busy(busy), .done(done),
        .pos_est(pos_est)
    );

    // Pin monitor: measures every phase in cycles
    int fall_cnt = 0, sel_falls = 0, rel_seen = 2;
    int v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0;
    int sel_age = 0, dir_age = 0, lo_len = 0, hi_len = 0, cyc_len = 0;
    int act_age = 0, gap = 0, dl = 0;
    bit first = 0, hold_pend = 0, dl_pend = 0;
    logic ps = 1'b1, pst = 1'b1, pd = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            ps = pot_sel_n; pst = pot_step_n; pd = pot_dir;
        end else begin
            sel_age++; dir_age++; lo_len++; hi_len++; cyc_len++; act_age++; gap++; dl++;
            if (pot_dir !== pd) begin
                dir_age = 0;
                if (!pot_step_n || !pst) v_r4++;
            end
            if (ps && !pot_sel_n) begin
                sel_falls++;
                sel_age = 0; act_age = 0; first = 1;
                if (hold_pend && gap < T_STORE) v_r6++;
                hold_pend = 0;
            end
            if (pst && !pot_step_n) begin
                if (pot_sel_n) v_r3++;
                fall_cnt++;
                if (first && sel_age < T_CS_SETUP) v_r4++;
                if (dir_age < T_DIR_SETUP) v_r4++;
                if (!first && (hi_len < T_INC_HI || cyc_len < T_CYC_MIN)) v_r5++;
                first = 0; lo_len = 0; cyc_len = 0; act_age = 0;
            end
            if (!pst && pot_step_n) begin
                if (!pot_sel_n && lo_len < T_INC_LO) v_r5++;
                if (pot_sel_n && dl_pend) begin
                    if (dl < T_DESEL) v_r7++;
                    dl_pend = 0;
                end
                hi_len = 0; act_age = 0;
            end
            if (!ps && pot_sel_n) begin
                if (pot_step_n) begin
                    rel_seen = 1; hold_pend = 1; gap = 0;
                    if (act_age < T_TAIL) v_r6++;
                end else begin
                    rel_seen = 0; dl_pend = 1; dl = 0;
                    if (act_age < T_TAIL) v_r7++;
                end
            end
            ps = pot_sel_n; pst = pot_step_n; pd = pot_dir;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_done(output bit got);
        int cnt = 0;
        got = done;
        while (!got && cnt < 5000) begin
            tick();
            cnt++;
            got = done;
        end
    endtask

    task automatic run_vec(input vec_t v);
        int e0;
        bit got;
        bit moves;
        moves = !(v.n == 0 && !v.st);
        load_en = 1'b1; load_pos = v.pre;
        tick();
        load_en = 1'b0;
        e0 = fall_cnt;
        rel_seen = 2;
        cmd_valid = 1'b1; cmd_steps = v.n; cmd_up = v.up; cmd_store = v.st;
        tick();
        cmd_valid = 1'b0;
        check(busy == moves, "R2 busy after accept", int'(busy), int'(moves));
        check(cmd_ready == !moves, "R2 ready after accept", int'(cmd_ready), int'(!moves));
        wait_done(got);
        check(got, "R2 done pulse", int'(got), 1);
        tick();
        check(done == 1'b0, "R2 done single cycle", int'(done), 0);
        check(pos_est == v.exp, "R3 R10 position estimate", int'(pos_est), int'(v.exp));
        check(fall_cnt - e0 == int'(v.n), "R3 step edge count", fall_cnt - e0, int'(v.n));
        check(rel_seen == int'(v.rel), "R6 R7 R8 R9 release level", rel_seen, int'(v.rel));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        bit got;
        int s0, e0;
        repeat (3) tick();
        // R1: reset state
        check(pot_sel_n == 1'b1, "R1 select parked", int'(pot_sel_n), 1);
        check(pot_step_n == 1'b1, "R1 strobe parked", int'(pot_step_n), 1);
        check(busy == 1'b0, "R1 not busy", int'(busy), 0);
        rst = 1'b0;
        tick();
        check(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
        check(pos_est == '0, "R1 reset estimate", int'(pos_est), 0);

        for (int i = 0; i < NV; i++) begin
            s0 = sel_falls;
            run_vec(VECS[i]);
            if (VECS[i].rel == 2'd2)
                check(sel_falls == s0, "R8 no select on empty command", sel_falls - s0, 0);
        end

        // R6: ready held low through commit hold-off, then a command right behind it
        load_en = 1'b1; load_pos = 7'd30; tick(); load_en = 1'b0;
        cmd_valid = 1'b1; cmd_steps = 7'd1; cmd_up = 1'b1; cmd_store = 1'b1;
        tick();
        cmd_valid = 1'b0;
        while (pot_sel_n == 1'b0) tick();
        tick();
        check(cmd_ready == 1'b0, "R6 ready low in hold-off", int'(cmd_ready), 0);
        repeat (20) tick();
        check(cmd_ready == 1'b0, "R6 ready low late in hold-off", int'(cmd_ready), 0);
        check(busy == 1'b1, "R6 busy in hold-off", int'(busy), 1);
        cmd_valid = 1'b1; cmd_steps = 7'd2; cmd_up = 1'b0; cmd_store = 1'b0;
        wait_done(got);
        tick();
        cmd_valid = 1'b0;
        check(pos_est == 7'd31, "R6 commit step result", int'(pos_est), 31);
        wait_done(got);
        check(got, "R2 done after queued command", int'(got), 1);
        tick();
        check(pos_est == 7'd29, "R4 direction reversed next command", int'(pos_est), 29);

        // R10: load held through a moving command wins over every step
        load_en = 1'b1; load_pos = 7'd60;
        e0 = fall_cnt;
        cmd_valid = 1'b1; cmd_steps = 7'd3; cmd_up = 1'b1; cmd_store = 1'b0;
        tick();
        cmd_valid = 1'b0;
        wait_done(got);
        tick();
        check(pos_est == 7'd60, "R10 load priority over step", int'(pos_est), 60);
        check(fall_cnt - e0 == 3, "R3 edges under load", fall_cnt - e0, 3);
        load_en = 1'b0;
        tick();

        check(v_r3 == 0, "R3 strobe fell while deselected", v_r3, 0);
        check(v_r4 == 0, "R4 select or direction setup violations", v_r4, 0);
        check(v_r5 == 0, "R5 pulse width violations", v_r5, 0);
        check(v_r6 == 0, "R6 commit tail or hold-off violations", v_r6, 0);
        check(v_r7 == 0, "R7 uncommitted release violations", v_r7, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule